// File: doc/BRIEF.md
# SPI Slave Block Readout Controller

This block is an SPI slave that serves framed block reads to an external master. Each transaction begins when slave select goes low. The master first shifts in a three-byte command. The slave then answers with a two-byte length, most significant byte first. After that it returns the payload bytes in order, while the master clocks dummy bytes that the slave does not use. Payload bytes come from a local read port: the block drives a byte address and takes the byte back on the next clock.

SCLK, MOSI and the active-low select are brought into the system clock domain through a synchronizer chain. All shifting is MSB first in SPI mode 0. MOSI is sampled on the rising SCLK edge and MISO changes on the falling edge.

The rising edge of slave select ends the block. At that point the byte counter, the bit counter and the command assembly buffer are all cleared, so bytes left over from an unfinished block can never shift the framing of the next command. Per-byte completion, transmit-load, block-done and abort indications let the surrounding logic follow the transfer.

Top module: `spi_blockread_slave`

## Requirements
- R1: The first three bytes received after select falls form the command, with the first byte placed in the top bits: cmd_o = {byte0, byte1, byte2}. cmd_o updates and cmd_valid_o pulses for one clock after the third byte completes.
- R2: Transaction bytes 3 and 4 on MISO carry the effective block length L, high byte first. L is sampled from len_req_i when the third command byte completes.
- R3: Payload byte k (k = 0..L-1) is transaction byte 5+k and equals the read data for rd_addr_o = k. MOSI content during and after the payload changes neither the MISO data nor cmd_o.
- R4: L = min(len_req_i, MAX_LEN), where MAX_LEN defaults to 1000. A request of 1500 yields the length bytes 0x03, 0xE8 and exactly 1000 payload bytes.
- R5: MISO is 0xFF during the three command bytes and on every byte after the payload. It is held high while select is high.
- R6: byte_done_o pulses for one clock for each byte whose 8 bits have all been exchanged, and for no partial byte.
- R7: tx_empty_o pulses for one clock each time a byte moves from the holding register into the shifter. This happens once when select falls and once at the falling SCLK edge that ends each byte, giving bytes+1 pulses per transaction.
- R8: When select rises, the byte count and the command buffer are cleared, so the next transaction again treats its first three bytes as the command.
- R9: If select rises while a byte is only partly shifted, abort_o is set and stays set until select next falls. A release on a byte boundary leaves it clear.
- R10: block_done_o pulses exactly once, in the clock after transaction byte 4+L completes. It does not pulse if select rises earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | SPI serial clock from master (asynchronous) |
| mosi_i | input | 1 | Master-out serial data |
| ss_n_i | input | 1 | Active-low slave select |
| miso_o | output | 1 | Slave-out serial data |
| len_req_i | input | 16 | Requested block length, sampled at end of command |
| rd_addr_o | output | ADDR_W | Payload byte address for the local read port |
| rd_data_i | input | 8 | Byte read at rd_addr_o |
| cmd_o | output | 24 | Last complete command |
| cmd_valid_o | output | 1 | One-clock pulse when cmd_o updates |
| byte_done_o | output | 1 | One-clock pulse per completed byte |
| tx_empty_o | output | 1 | One-clock pulse when the shifter loads a byte |
| block_done_o | output | 1 | One-clock pulse when the last payload byte completes |
| abort_o | output | 1 | Sticky mid-byte release flag |

## Verification
The main function is exercised with several kinds of transaction:
- Full blocks of 4, 0 and 3 bytes tell the framing of the header, the length and the payload apart, including the empty-payload edge.
- A 1500-byte request runs to completion to show the clamp at 1000 and the final block-done.
- The same block is read twice, once with all-zero MOSI and once with varying MOSI, to show that the dummy bytes change nothing.
- One transaction is released mid-byte and another on a byte boundary in the middle of the payload. Each is followed by a fresh transaction, which separates the sticky abort from a clean early end and shows that the counters restart.

The bench's reference model predicts every MISO byte and every pulse count. The abort flag and the idle MISO level are checked on every clock.

// File: rtl/spi_blk_pkg.sv
package spi_blk_pkg;
   localparam int HDR_BYTES = 3;
   localparam int LEN_BYTES = 2;
   localparam int FIRST_DATA = HDR_BYTES + LEN_BYTES;
   localparam logic [7:0] FILL_BYTE = 8'hFF;

   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_LEN  = 2'd1,
      PH_DATA = 2'd2,
      PH_TAIL = 2'd3
   } phase_e;
endpackage

// File: rtl/spi_blk_sync.sv
module spi_blk_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[0] <= RST_VAL;
               else        stg[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[s] <= RST_VAL;
               else        stg[s] <= stg[s-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_blk_shifter.sv
module spi_blk_shifter (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sclk_s,
   input  logic       mosi_s,
   input  logic       ss_s,
   input  logic [7:0] tx_hold,
   output logic       miso,
   output logic       byte_done,
   output logic [7:0] rx_byte,
   output logic       tx_load,
   output logic       mid_byte,
   output logic       ss_rise,
   output logic       ss_fall
);
   logic       sclk_q, ss_q;
   logic [2:0] bit_cnt;
   logic [6:0] rx_sh;
   logic [7:0] tx_sh;
   logic       active, rise, fall;

   assign active   = ~ss_s;
   assign rise     = active &  sclk_s & ~sclk_q;
   assign fall     = active & ~sclk_s &  sclk_q;
   assign ss_fall  = ~ss_s &  ss_q;
   assign ss_rise  =  ss_s & ~ss_q;
   assign tx_load  = ss_fall | (fall & (bit_cnt == 3'd0));
   assign mid_byte = (bit_cnt != 3'd0);
   assign miso     = active ? tx_sh[7] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q    <= 1'b0;
         ss_q      <= 1'b1;
         bit_cnt   <= '0;
         rx_sh     <= '0;
         rx_byte   <= '0;
         byte_done <= 1'b0;
         tx_sh     <= 8'hFF;
      end else begin
         sclk_q    <= sclk_s;
         ss_q      <= ss_s;
         byte_done <= 1'b0;
         if (!active) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
         end else if (rise) begin
            rx_sh   <= {rx_sh[5:0], mosi_s};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
               byte_done <= 1'b1;
               rx_byte   <= {rx_sh, mosi_s};
            end
         end
         if (tx_load)     tx_sh <= tx_hold;
         else if (fall)   tx_sh <= {tx_sh[6:0], 1'b1};
         else if (!active) tx_sh <= 8'hFF;
      end
   end

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> !byte_done);
   // R7
   load_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_load && byte_done));
endmodule

// File: rtl/spi_blk_seq.sv
module spi_blk_seq
   import spi_blk_pkg::*;
#(
   parameter int MAX_LEN = 1000,
   parameter int LEN_W   = 10,
   parameter int ADDR_W  = 10,
   parameter int CNT_W   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_done,
   input  logic [7:0]        rx_byte,
   input  logic              ss_s,
   input  logic              ss_rise,
   input  logic              ss_fall,
   input  logic              mid_byte,
   input  logic [15:0]       len_req,
   input  logic [7:0]        rd_data,
   output logic [7:0]        tx_hold,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [23:0]       cmd,
   output logic              cmd_valid,
   output logic              block_done,
   output logic              abort
);
   logic [CNT_W-1:0] cnt;
   logic [LEN_W-1:0] len_q;
   logic [15:0]      cmd_sh;
   logic [CNT_W-1:0] last_idx;
   logic [15:0]      len16;
   phase_e           phase;
   logic [7:0]       hold_nxt;

   assign last_idx = CNT_W'(len_q) + CNT_W'(FIRST_DATA - 1);
   assign len16    = 16'(len_q);

   always_comb begin
      if (cnt < CNT_W'(HDR_BYTES))       phase = PH_CMD;
      else if (cnt < CNT_W'(FIRST_DATA)) phase = PH_LEN;
      else if (cnt <= last_idx)          phase = PH_DATA;
      else                               phase = PH_TAIL;
   end

   always_comb begin
      rd_addr  = '0;
      hold_nxt = FILL_BYTE;
      case (phase)
         PH_LEN:  hold_nxt = (cnt == CNT_W'(HDR_BYTES)) ? len16[15:8] : len16[7:0];
         PH_DATA: begin
            rd_addr  = ADDR_W'(cnt - CNT_W'(FIRST_DATA));
            hold_nxt = rd_data;
         end
         default: hold_nxt = FILL_BYTE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         len_q      <= '0;
         cmd_sh     <= '0;
         cmd        <= '0;
         cmd_valid  <= 1'b0;
         block_done <= 1'b0;
         abort      <= 1'b0;
         tx_hold    <= FILL_BYTE;
      end else begin
         cmd_valid  <= 1'b0;
         block_done <= 1'b0;
         tx_hold    <= hold_nxt;
         if (ss_fall)                abort <= 1'b0;
         else if (ss_rise && mid_byte) abort <= 1'b1;
         if (ss_s) begin
            cnt    <= '0;
            len_q  <= '0;
            cmd_sh <= '0;
         end else if (byte_done) begin
            if (cnt != '1) cnt <= cnt + CNT_W'(1);
            if (phase == PH_CMD) begin
               cmd_sh <= {cmd_sh[7:0], rx_byte};
               if (cnt == CNT_W'(HDR_BYTES - 1)) begin
                  cmd       <= {cmd_sh, rx_byte};
                  cmd_valid <= 1'b1;
                  len_q     <= (len_req > 16'(MAX_LEN)) ? LEN_W'(MAX_LEN) : len_req[LEN_W-1:0];
               end
            end
            if (cnt == last_idx) block_done <= 1'b1;
         end
      end
   end

   // R4
   len_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      len_q <= LEN_W'(MAX_LEN));
   // R8
   release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ss_rise |=> (cnt == '0));
   // R9
   abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(abort) |-> $past(ss_rise));
   // R10
   block_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      block_done |=> !block_done);
   // R1
   cmd_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(byte_done));
endmodule

// File: rtl/spi_blockread_slave.sv
module spi_blockread_slave #(
   parameter int MAX_LEN     = 1000,
   parameter int SYNC_STAGES = 2,
   localparam int LEN_W  = $clog2(MAX_LEN + 1),
   localparam int ADDR_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
   localparam int CNT_W  = $clog2(MAX_LEN + spi_blk_pkg::FIRST_DATA + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              mosi_i,
   input  logic              ss_n_i,
   output logic              miso_o,
   input  logic [15:0]       len_req_i,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [7:0]        rd_data_i,
   output logic [23:0]       cmd_o,
   output logic              cmd_valid_o,
   output logic              byte_done_o,
   output logic              tx_empty_o,
   output logic              block_done_o,
   output logic              abort_o
);
   generate
      if (MAX_LEN < 1 || MAX_LEN > 65535) begin : g_bad_len
         $error("MAX_LEN must be within 1..65535 to fit two length bytes");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic       sclk_s, mosi_s, ss_s;
   logic [7:0] tx_hold, rx_byte;
   logic       mid_byte, ss_rise, ss_fall;

   spi_blk_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ss_n_i, sclk_i, mosi_i}),
      .q     ({ss_s, sclk_s, mosi_s})
   );

   spi_blk_shifter u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s    (sclk_s),
      .mosi_s    (mosi_s),
      .ss_s      (ss_s),
      .tx_hold   (tx_hold),
      .miso      (miso_o),
      .byte_done (byte_done_o),
      .rx_byte   (rx_byte),
      .tx_load   (tx_empty_o),
      .mid_byte  (mid_byte),
      .ss_rise   (ss_rise),
      .ss_fall   (ss_fall)
   );

   spi_blk_seq #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_done  (byte_done_o),
      .rx_byte    (rx_byte),
      .ss_s       (ss_s),
      .ss_rise    (ss_rise),
      .ss_fall    (ss_fall),
      .mid_byte   (mid_byte),
      .len_req    (len_req_i),
      .rd_data    (rd_data_i),
      .tx_hold    (tx_hold),
      .rd_addr    (rd_addr_o),
      .cmd        (cmd_o),
      .cmd_valid  (cmd_valid_o),
      .block_done (block_done_o),
      .abort      (abort_o)
   );

   // R10
   done_has_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      block_done_o |-> $past(byte_done_o));
endmodule

// File: tb/spi_blockread_slave_test.sv
module spi_blockread_slave_test;
   localparam int H = 6;
   localparam int MAXL = 1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0, mosi = 1'b0, ss_n = 1'b1;
   logic [15:0] len_req = '0;
   logic [9:0]  rd_addr;
   logic [7:0]  rd_data;
   logic        miso, cmd_valid, byte_done, tx_empty, block_done, abort;
   logic [23:0] cmd;

   int total = 0, fails = 0;
   int n_bd = 0, n_te = 0, n_blk = 0, n_cv = 0;
   bit steady = 0, exp_abort = 0;

   always #2.5 clk = ~clk;
   assign rd_data = rd_addr[7:0] ^ 8'h5A;

   spi_blockread_slave uut (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .mosi_i(mosi), .ss_n_i(ss_n),
      .miso_o(miso), .len_req_i(len_req), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
      .cmd_o(cmd), .cmd_valid_o(cmd_valid), .byte_done_o(byte_done),
      .tx_empty_o(tx_empty), .block_done_o(block_done), .abort_o(abort)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) if (rst_n) begin
      if (byte_done) n_bd++;
      if (tx_empty) n_te++;
      if (block_done) n_blk++;
      if (cmd_valid) n_cv++;
   end

   // per-clock model comparison of abort flag and idle MISO level
   always @(negedge clk) if (rst_n && steady) begin
      chk(abort == exp_abort, "R9", "abort flag", abort, exp_abort);
      if (ss_n) chk(miso == 1'b1, "R5", "idle miso", miso, 1);
   end

   function automatic int eff_len(input int req);
      return (req > MAXL) ? MAXL : req;
   endfunction

   function automatic logic [7:0] model_byte(input int idx, input int l);
      if (idx < 3) return 8'hFF;
      if (idx == 3) return 8'((l >> 8) & 255);
      if (idx == 4) return 8'(l & 255);
      if (idx < 5 + l) return 8'((idx - 5) & 255) ^ 8'h5A;
      return 8'hFF;
   endfunction

   task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
      rx = 8'h00;
      for (int i = 0; i < nbits; i++) begin
         mosi = tx[7-i];
         repeat (H) @(negedge clk);
         rx[7-i] = miso;
         sclk = 1'b1;
         repeat (H) @(negedge clk);
         sclk = 1'b0;
      end
   endtask

   task automatic select(input logic lvl);
      steady = 0;
      @(negedge clk);
      ss_n = lvl;
      repeat (8) @(negedge clk);
      steady = 1;
   endtask

   // run a transaction of nbytes full bytes plus optional partial bits
   task automatic run(input logic [23:0] c, input int req, input int nbytes,
                      input int part_bits, input int mode);
      logic [7:0] rx, tx;
      int l;
      l = eff_len(req);
      len_req = 16'(req);
      n_bd = 0; n_te = 0; n_blk = 0; n_cv = 0;
      select(1'b0);
      exp_abort = 0;
      for (int b = 0; b < nbytes; b++) begin
         if (b < 3) tx = c[23 - 8*b -: 8];
         else if (mode == 0) tx = 8'h00;
         else tx = 8'(b * 37) ^ 8'hA5;
         xfer(tx, 8, rx);
         if (b < 3 || b >= 5 + l)
            chk(rx == model_byte(b, l), "R5", $sformatf("fill byte %0d", b), rx, model_byte(b, l));
         else if (b < 5)
            chk(rx == model_byte(b, l), (req > MAXL) ? "R4" : "R2", $sformatf("length byte %0d", b), rx, model_byte(b, l));
         else if (b == 5 || b == 4 + l || l < 8)
            chk(rx == model_byte(b, l), "R3", $sformatf("data byte %0d", b), rx, model_byte(b, l));
         else if (rx != model_byte(b, l))
            chk(1'b0, "R3", $sformatf("data byte %0d", b), rx, model_byte(b, l));
      end
      if (part_bits > 0) xfer(8'hC3, part_bits, rx);
      repeat (H) @(negedge clk);
      if (nbytes >= 3) begin
         chk(cmd == c, mode ? "R3" : "R1", "command after block", cmd, c);
         chk(n_cv == 1, "R1", "cmd_valid pulses", n_cv, 1);
      end
      chk(n_bd == nbytes, "R6", "byte_done pulses", n_bd, nbytes);
      chk(n_te == nbytes + 1, "R7", "tx_empty pulses", n_te, nbytes + 1);
      chk(n_blk == ((nbytes >= 5 + l) ? 1 : 0), "R10", "block_done pulses", n_blk, (nbytes >= 5 + l) ? 1 : 0);
      select(1'b1);
      exp_abort = (part_bits > 0);
      @(negedge clk);
      chk(abort == exp_abort, "R9", "abort after release", abort, exp_abort);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(miso == 1'b1, "R5", "reset miso", miso, 1);
      chk(block_done == 1'b0, "R10", "reset block_done", block_done, 0);
      chk(abort == 1'b0, "R9", "reset abort", abort, 0);
      chk(cmd_valid == 1'b0, "R1", "reset cmd_valid", cmd_valid, 0);
      chk(tx_empty == 1'b0, "R7", "reset tx_empty", tx_empty, 0);
      steady = 1;
      // basic block, zero dummies, two tail bytes
      run(24'hA1B2C3, 4, 11, 0, 0);
      // same block with varying dummy bytes: data must not change
      run(24'h5E6F70, 4, 11, 0, 1);
      // empty payload
      run(24'h010203, 0, 6, 0, 1);
      // mid-byte release (R9), then clean restart (R8)
      run(24'hDEAD01, 7, 2, 3, 1);
      run(24'h123456, 2, 8, 0, 1);
      // byte-boundary release inside payload (R8, R10)
      run(24'h0F0E0D, 5, 7, 0, 1);
      run(24'h778899, 3, 9, 0, 0);
      // clamp to maximum (R4)
      run(24'hC0FFEE, 1500, 1006, 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      chk(1'b0, "R6", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule